// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a 64-bit load/store core whose register set is organised as overlapping windows. A 5-bit architectural index names one of 32 visible registers. Index 0 is a constant zero. Indices 1 to 7 reach seven shared global registers. Indices 8 to 31 reach a window of sixteen physical registers chosen from the held window pointer. Indices 16 to 31 reach the window one step behind the pointer. The upper eight of those registers are the same physical entries that the previous window sees as indices 8 to 15.

There are two combinational read ports and one write port that commits at the clock edge. Each port handles a full 64-bit access, a 32-bit access and a paired access. The paired access joins the low words of two neighbouring registers into one 64-bit value. Every access also reports a flat physical tag for each entry it touches, so that the pipeline can track dependencies.

The block also holds five 5-bit window bookkeeping counters. One of them is the window pointer that drives the mapping. Each counter has its own reset value and can be written through a small select/data port. Spill and fill trap handling sits elsewhere.

Top module: `win_regfile`

## Requirements
- R1: Index 0 reads as 64'h0 and reports no valid tag. A write to index 0 reports no valid tag and changes no register.
- R2: Indices 1 to 7 reach seven global registers that are the same for every window pointer value. The tag of a global register equals its index.
- R3: For index i of 8 or above, the window is ((P mod 8) − i/16 + 8) mod 8, where P is the held window pointer. The entry within that window is i & 15. As a result, index 24+k under pointer P reaches the same entry as index 8+k under pointer P−1.
- R4: The tag of a windowed register is 16·window + (i & 15) + 8, in the range 8 to 135.
- R5: Mode 2'b00 (and the spare code 2'b11) reads and writes all 64 bits unchanged.
- R6: Mode 2'b01 reads the low 32 bits with the upper half zero. Mode 2'b01 writes the low 32 bits sign-extended to 64 bits.
- R7: Mode 2'b10 (paired) writes the upper 32 bits of the data, zero-extended, to register n, and the lower 32 bits, zero-extended, to register n+1. A paired read returns {low word of n, low word of n+1}. Tag 1 reports the entry for n+1. Tag 1 is valid only in paired mode.
- R8: In a paired access at index 31, the second index wraps to 0. Its tag is not valid, the low word of a paired write is lost, and a paired read returns zero in its low half.
- R9: Reads are combinational and writes take effect at the rising clock edge. A read of an entry being written in the same cycle returns the old value when byp_en is 0 and the new value when byp_en is 1.
- R10: The counters use select codes 0 = window pointer, 1 = save room, 2 = restore room, 3 = other, 4 = clean. After a synchronous active-low reset they hold 0, 6, 0, 0 and 7. A write with select 5 to 7 changes none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_idx | input | 5 | Read port A architectural index |
| ra_mode | input | 2 | Read port A access mode |
| ra_data | output | 64 | Read port A data |
| ra_tag0 | output | 8 | Physical tag of register n on port A |
| ra_tag0_vld | output | 1 | ra_tag0 is meaningful |
| ra_tag1 | output | 8 | Physical tag of register n+1 on port A |
| ra_tag1_vld | output | 1 | ra_tag1 is meaningful |
| rb_idx | input | 5 | Read port B architectural index |
| rb_mode | input | 2 | Read port B access mode |
| rb_data | output | 64 | Read port B data |
| rb_tag0 | output | 8 | Physical tag of register n on port B |
| rb_tag0_vld | output | 1 | rb_tag0 is meaningful |
| rb_tag1 | output | 8 | Physical tag of register n+1 on port B |
| rb_tag1_vld | output | 1 | rb_tag1 is meaningful |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural index |
| wr_mode | input | 2 | Write access mode |
| wr_data | input | 64 | Write data |
| byp_en | input | 1 | Forward same-cycle write data to reads |
| wr_tag0 | output | 8 | Physical tag written for register n |
| wr_tag0_vld | output | 1 | wr_tag0 is meaningful |
| wr_tag1 | output | 8 | Physical tag written for register n+1 |
| wr_tag1_vld | output | 1 | wr_tag1 is meaningful |
| ctl_we | input | 1 | Counter write enable |
| ctl_sel | input | 3 | Counter select |
| ctl_wdata | input | 5 | Counter write value |
| win_ptr | output | 5 | Current window pointer |
| win_save_room | output | 5 | Save-room counter |
| win_restore_room | output | 5 | Restore-room counter |
| win_other_cnt | output | 5 | Other-windows counter |
| win_clean_cnt | output | 5 | Clean-windows counter |

## Verification
The assertions take for granted that every input is a known value from the first edge after reset onward. They also assume the window pointer only changes through the counter port, so the tag outputs depend on one held register plus the current indices. The bench drives all inputs just after the falling edge and holds them steady across the following rising edge. It changes the window pointer only between accesses. It fills every physical entry before reading any, so no read ever returns an unwritten entry. The bench tracks the pointer it has written, including values of 8 or more, and uses it to predict tags.

// File: rtl/win_rf_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the windowed register file.
// Assumes the mode and counter-select codes below are fixed by the pipeline.
package win_rf_pkg;
    localparam logic [1:0] ACC_W64  = 2'b00;
    localparam logic [1:0] ACC_W32  = 2'b01;
    localparam logic [1:0] ACC_PAIR = 2'b10;

    localparam logic [2:0] CSEL_PTR     = 3'd0;
    localparam logic [2:0] CSEL_SAVE    = 3'd1;
    localparam logic [2:0] CSEL_RESTORE = 3'd2;
    localparam logic [2:0] CSEL_OTHER   = 3'd3;
    localparam logic [2:0] CSEL_CLEAN   = 3'd4;
endpackage

// File: rtl/win_rf_map.sv
`timescale 1ns/1ps
// Maps an architectural index and window pointer to a flat physical tag.
// Assumes the index is exactly two window groups wide (IDX_W = log2(2*WIN_REGS)),
// that NUM_GLB + 1 is the first windowed index, and that tag 0 is never a real entry.
module win_rf_map #(
    parameter int NUM_WIN  = 8,
    parameter int WIN_REGS = 16,
    parameter int NUM_GLB  = 7,
    parameter int CNT_W    = 5,
    parameter int IDX_W    = 5,
    parameter int TAG_W    = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] cwp,
    output logic [TAG_W-1:0] tag,
    output logic             vld
);
    localparam int ENT_W    = $clog2(WIN_REGS);
    localparam int WIN_W    = $clog2(NUM_WIN);
    localparam int SUM_W    = CNT_W + 2;
    localparam int GLB_BASE = NUM_GLB + 1;

    logic [IDX_W-ENT_W-1:0] grp;
    logic [ENT_W-1:0]       ent;
    logic [SUM_W-1:0]       sum;
    logic [WIN_W-1:0]       win;

    // Pick the window behind the pointer by the index's group and form the tag.
    always_comb begin
        grp = idx[IDX_W-1:ENT_W];
        ent = idx[ENT_W-1:0];
        sum = SUM_W'(cwp % CNT_W'(NUM_WIN)) + SUM_W'(NUM_WIN) - SUM_W'(grp);
        win = WIN_W'(sum % SUM_W'(NUM_WIN));
        vld = (idx != '0);
        if (idx == '0) begin
            tag = '0;
        end else if (idx < IDX_W'(GLB_BASE)) begin
            tag = TAG_W'(idx);
        end else begin
            tag = TAG_W'(GLB_BASE) + TAG_W'(win) * TAG_W'(WIN_REGS) + TAG_W'(ent);
        end
    end
endmodule

// File: rtl/win_rf_store.sv
`timescale 1ns/1ps
// Flat physical storage addressed by tag, with two write slots and NRD read taps.
// Assumes the two write slots never target the same tag in one cycle and that
// tag 0 is never written; storage itself is not reset.
module win_rf_store #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 136,
    parameter int TAG_W  = 8,
    parameter int NRD    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  we,
    input  logic [1:0][TAG_W-1:0]       wa,
    input  logic [1:0][DATA_W-1:0]      wd,
    input  logic                        byp_en,
    input  logic [NRD-1:0][TAG_W-1:0]   ra,
    output logic [NRD-1:0][DATA_W-1:0]  rd
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Commit both write slots at the clock edge.
    always_ff @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (we[s]) begin
                mem[wa[s]] <= wd[s];
            end
        end
    end

    // Read every tap, optionally forwarding a same-cycle write.
    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            rd[r] = mem[ra[r]];
            for (int s = 0; s < 2; s++) begin
                if (byp_en && we[s] && (wa[s] == ra[r])) begin
                    rd[r] = wd[s];
                end
            end
        end
    end

    // R9: a write slot lands in storage by the next cycle.
    assert_wr_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we[0] |=> (mem[$past(wa[0])] == $past(wd[0])));
    assert_wr_commit_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we[1] |=> (mem[$past(wa[1])] == $past(wd[1])));
    // R1: slot tags are never the reserved zero tag.
    assert_no_zero_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we[0] |-> wa[0] != '0) and (we[1] |-> wa[1] != '0));
endmodule

// File: rtl/win_rf_ctrs.sv
`timescale 1ns/1ps
// Window bookkeeping counters, including the pointer that drives the mapping.
// Assumes select codes from win_rf_pkg; unknown selects are ignored.
module win_rf_ctrs
    import win_rf_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] ptr,
    output logic [CNT_W-1:0] save_room,
    output logic [CNT_W-1:0] restore_room,
    output logic [CNT_W-1:0] other_cnt,
    output logic [CNT_W-1:0] clean_cnt
);
    localparam logic [CNT_W-1:0] SAVE_RST  = CNT_W'(NUM_WIN - 2);
    localparam logic [CNT_W-1:0] CLEAN_RST = CNT_W'(NUM_WIN - 1);

    // Reset to architectural values or load the selected counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr          <= '0;
            save_room    <= SAVE_RST;
            restore_room <= '0;
            other_cnt    <= '0;
            clean_cnt    <= CLEAN_RST;
        end else if (we) begin
            case (sel)
                CSEL_PTR:     ptr          <= wdata;
                CSEL_SAVE:    save_room    <= wdata;
                CSEL_RESTORE: restore_room <= wdata;
                CSEL_OTHER:   other_cnt    <= wdata;
                CSEL_CLEAN:   clean_cnt    <= wdata;
                default:      ;
            endcase
        end
    end

    // R10: first cycle out of reset shows the reset values.
    assert_rst_vals_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ptr == '0 && save_room == SAVE_RST && restore_room == '0
                           && other_cnt == '0 && clean_cnt == CLEAN_RST));
    // R10: an unused select leaves every counter untouched.
    assert_bad_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel > CSEL_CLEAN) |=> ($stable(ptr) && $stable(save_room)
            && $stable(restore_room) && $stable(other_cnt) && $stable(clean_cnt)));
endmodule

// File: rtl/win_regfile.sv
`timescale 1ns/1ps
// Windowed integer register file: two combinational read ports, one write port,
// 64/32/paired access forms and per-access physical tags.
// Assumes inputs are stable around the clock edge and the pointer changes only
// through the counter port.
module win_regfile
    import win_rf_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int WIN_REGS = 16,
    parameter int NUM_GLB  = 7,
    parameter int DATA_W   = 64,
    parameter int CNT_W    = 5,
    localparam int IDX_W   = $clog2(2 * WIN_REGS),
    localparam int TAG_W   = $clog2(NUM_GLB + 1 + NUM_WIN * WIN_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [1:0]        ra_mode,
    output logic [DATA_W-1:0] ra_data,
    output logic [TAG_W-1:0]  ra_tag0,
    output logic              ra_tag0_vld,
    output logic [TAG_W-1:0]  ra_tag1,
    output logic              ra_tag1_vld,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [1:0]        rb_mode,
    output logic [DATA_W-1:0] rb_data,
    output logic [TAG_W-1:0]  rb_tag0,
    output logic              rb_tag0_vld,
    output logic [TAG_W-1:0]  rb_tag1,
    output logic              rb_tag1_vld,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_mode,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byp_en,
    output logic [TAG_W-1:0]  wr_tag0,
    output logic              wr_tag0_vld,
    output logic [TAG_W-1:0]  wr_tag1,
    output logic              wr_tag1_vld,
    input  logic              ctl_we,
    input  logic [2:0]        ctl_sel,
    input  logic [CNT_W-1:0]  ctl_wdata,
    output logic [CNT_W-1:0]  win_ptr,
    output logic [CNT_W-1:0]  win_save_room,
    output logic [CNT_W-1:0]  win_restore_room,
    output logic [CNT_W-1:0]  win_other_cnt,
    output logic [CNT_W-1:0]  win_clean_cnt
);
    localparam int GLB_BASE = NUM_GLB + 1;
    localparam int DEPTH    = GLB_BASE + NUM_WIN * WIN_REGS;
    localparam int HALF_W   = DATA_W / 2;
    localparam int NMAP     = 6;

    logic [NMAP-1:0][IDX_W-1:0] map_idx;
    logic [NMAP-1:0][TAG_W-1:0] map_tag;
    logic [NMAP-1:0]            map_vld;
    logic [1:0][IDX_W-1:0]      prt_idx;
    logic [1:0][1:0]            prt_mode;
    logic [1:0][DATA_W-1:0]     prt_data;
    logic [1:0]                 prt_t1v;
    logic [3:0][TAG_W-1:0]      st_ra;
    logic [3:0][DATA_W-1:0]     st_rd;
    logic [1:0]                 st_we;
    logic [1:0][TAG_W-1:0]      st_wa;
    logic [1:0][DATA_W-1:0]     st_wd;

    // Map slots: 0/1 port A n, n+1; 2/3 port B; 4/5 write port.
    assign map_idx[0] = ra_idx;
    assign map_idx[1] = ra_idx + IDX_W'(1);
    assign map_idx[2] = rb_idx;
    assign map_idx[3] = rb_idx + IDX_W'(1);
    assign map_idx[4] = wr_idx;
    assign map_idx[5] = wr_idx + IDX_W'(1);

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        win_rf_map #(
            .NUM_WIN (NUM_WIN),
            .WIN_REGS(WIN_REGS),
            .NUM_GLB (NUM_GLB),
            .CNT_W   (CNT_W),
            .IDX_W   (IDX_W),
            .TAG_W   (TAG_W)
        ) u_map (
            .idx(map_idx[g]),
            .cwp(win_ptr),
            .tag(map_tag[g]),
            .vld(map_vld[g])
        );
    end

    win_rf_ctrs #(
        .NUM_WIN(NUM_WIN),
        .CNT_W  (CNT_W)
    ) u_ctrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (ctl_we),
        .sel         (ctl_sel),
        .wdata       (ctl_wdata),
        .ptr         (win_ptr),
        .save_room   (win_save_room),
        .restore_room(win_restore_room),
        .other_cnt   (win_other_cnt),
        .clean_cnt   (win_clean_cnt)
    );

    assign st_ra    = map_tag[3:0];
    assign st_wa[0] = map_tag[4];
    assign st_wa[1] = map_tag[5];

    win_rf_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .TAG_W (TAG_W),
        .NRD   (4)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .wa    (st_wa),
        .wd    (st_wd),
        .byp_en(byp_en),
        .ra    (st_ra),
        .rd    (st_rd)
    );

    // Shape write data per mode and gate slots by index validity.
    always_comb begin
        st_we[0] = wr_en && map_vld[4];
        st_we[1] = wr_en && (wr_mode == ACC_PAIR) && map_vld[5];
        st_wd[1] = {{HALF_W{1'b0}}, wr_data[HALF_W-1:0]};
        case (wr_mode)
            ACC_W32:  st_wd[0] = {{HALF_W{wr_data[HALF_W-1]}}, wr_data[HALF_W-1:0]};
            ACC_PAIR: st_wd[0] = {{HALF_W{1'b0}}, wr_data[DATA_W-1:HALF_W]};
            default:  st_wd[0] = wr_data;
        endcase
    end

    assign wr_tag0     = map_tag[4];
    assign wr_tag0_vld = st_we[0];
    assign wr_tag1     = map_tag[5];
    assign wr_tag1_vld = st_we[1];

    assign prt_idx[0]  = ra_idx;
    assign prt_idx[1]  = rb_idx;
    assign prt_mode[0] = ra_mode;
    assign prt_mode[1] = rb_mode;

    // Assemble read data for both ports from their two taps.
    always_comb begin
        logic [DATA_W-1:0] d0;
        logic [DATA_W-1:0] d1;
        for (int p = 0; p < 2; p++) begin
            d0 = map_vld[2*p]   ? st_rd[2*p]   : '0;
            d1 = map_vld[2*p+1] ? st_rd[2*p+1] : '0;
            case (prt_mode[p])
                ACC_W32:  prt_data[p] = {{HALF_W{1'b0}}, d0[HALF_W-1:0]};
                ACC_PAIR: prt_data[p] = {d0[HALF_W-1:0], d1[HALF_W-1:0]};
                default:  prt_data[p] = d0;
            endcase
            prt_t1v[p] = (prt_mode[p] == ACC_PAIR) && map_vld[2*p+1];
        end
    end

    assign ra_data     = prt_data[0];
    assign ra_tag0     = map_tag[0];
    assign ra_tag0_vld = map_vld[0];
    assign ra_tag1     = map_tag[1];
    assign ra_tag1_vld = prt_t1v[0];
    assign rb_data     = prt_data[1];
    assign rb_tag0     = map_tag[2];
    assign rb_tag0_vld = map_vld[2];
    assign rb_tag1     = map_tag[3];
    assign rb_tag1_vld = prt_t1v[1];

    // R1: the zero index reads zero with no tag.
    assert_zero_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (prt_idx[0] == '0 && ra_mode != ACC_PAIR) |-> (ra_data == '0 && !ra_tag0_vld));
    // R2: a global index reports itself as tag.
    assert_global_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx != '0 && ra_idx < IDX_W'(GLB_BASE)) |-> (ra_tag0_vld && ra_tag0 == TAG_W'(ra_idx)));
    // R4: windowed tags fall in the windowed range.
    assert_win_tag_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx >= IDX_W'(GLB_BASE)) |-> (rb_tag0 >= TAG_W'(GLB_BASE) && rb_tag0 < TAG_W'(DEPTH)));
    // R7: tag 1 only appears in the paired mode.
    assert_tag1_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_mode != ACC_PAIR) |-> !ra_tag1_vld);
    // R8: a paired write at the top index loses its second half.
    assert_pair_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == ACC_PAIR && wr_idx == '1) |-> !wr_tag1_vld);
endmodule

// File: tb/test_win_regfile.sv
`timescale 1ns/1ps
module test_win_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  ra_idx, rb_idx, wr_idx;
    logic [1:0]  ra_mode, rb_mode, wr_mode;
    logic [63:0] ra_data, rb_data, wr_data;
    logic [7:0]  ra_tag0, ra_tag1, rb_tag0, rb_tag1, wr_tag0, wr_tag1;
    logic        ra_tag0_vld, ra_tag1_vld, rb_tag0_vld, rb_tag1_vld, wr_tag0_vld, wr_tag1_vld;
    logic        wr_en, byp_en, ctl_we;
    logic [2:0]  ctl_sel;
    logic [4:0]  ctl_wdata, win_ptr, win_save_room, win_restore_room, win_other_cnt, win_clean_cnt;

    always #4 clk = ~clk;

    win_regfile i_win_regfile (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_mode(ra_mode), .ra_data(ra_data),
        .ra_tag0(ra_tag0), .ra_tag0_vld(ra_tag0_vld), .ra_tag1(ra_tag1), .ra_tag1_vld(ra_tag1_vld),
        .rb_idx(rb_idx), .rb_mode(rb_mode), .rb_data(rb_data),
        .rb_tag0(rb_tag0), .rb_tag0_vld(rb_tag0_vld), .rb_tag1(rb_tag1), .rb_tag1_vld(rb_tag1_vld),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode), .wr_data(wr_data), .byp_en(byp_en),
        .wr_tag0(wr_tag0), .wr_tag0_vld(wr_tag0_vld), .wr_tag1(wr_tag1), .wr_tag1_vld(wr_tag1_vld),
        .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .win_ptr(win_ptr), .win_save_room(win_save_room), .win_restore_room(win_restore_room),
        .win_other_cnt(win_other_cnt), .win_clean_cnt(win_clean_cnt)
    );

    int checks = 0;
    int fails = 0;
    int cur_cwp = 0;
    bit done = 0;
    logic [63:0] model [136];

    // Physical tag from the requirement formulas (R2, R3, R4).
    function automatic int ptag(int c, int idx);
        int i = idx % 32;
        int w;
        if (i == 0) return 0;
        if (i < 8) return i;
        w = ((c % 8) - (i / 16) + 8) % 8;
        return 16 * w + (i % 16) + 8;
    endfunction

    function automatic logic [63:0] mdat(int t);
        return (t == 0) ? 64'd0 : model[t];
    endfunction

    function automatic logic [63:0] exp_rd(int idx, int mode);
        logic [63:0] d0 = mdat(ptag(cur_cwp, idx));
        logic [63:0] d1 = mdat(ptag(cur_cwp, idx + 1));
        case (mode)
            1: return {32'd0, d0[31:0]};
            2: return {d0[31:0], d1[31:0]};
            default: return d0;
        endcase
    endfunction

    function automatic void model_upd(int idx, int mode, logic [63:0] d);
        int t0 = ptag(cur_cwp, idx);
        int t1 = ptag(cur_cwp, idx + 1);
        if (t0 != 0) begin
            case (mode)
                1: model[t0] = {{32{d[31]}}, d[31:0]};
                2: model[t0] = {32'd0, d[63:32]};
                default: model[t0] = d;
            endcase
        end
        if (mode == 2 && t1 != 0) model[t1] = {32'd0, d[31:0]};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd_chk(int port, int idx, int mode, string req);
        logic [63:0] d;
        logic [7:0] t0, t1;
        logic v0, v1;
        int e0, e1;
        bit ev1;
        @(negedge clk);
        if (port == 0) begin ra_idx = 5'(idx); ra_mode = 2'(mode); end
        else begin rb_idx = 5'(idx); rb_mode = 2'(mode); end
        #1;
        if (port == 0) begin d = ra_data; t0 = ra_tag0; v0 = ra_tag0_vld; t1 = ra_tag1; v1 = ra_tag1_vld; end
        else begin d = rb_data; t0 = rb_tag0; v0 = rb_tag0_vld; t1 = rb_tag1; v1 = rb_tag1_vld; end
        e0 = ptag(cur_cwp, idx);
        e1 = ptag(cur_cwp, idx + 1);
        ev1 = (mode == 2) && (e1 != 0);
        chk(req, "read data", d, exp_rd(idx, mode));
        chk(req, "read tag0", 64'({v0, v0 ? t0 : 8'd0}), 64'({e0 != 0, 8'(e0)}));
        chk(req, "read tag1", 64'({v1, v1 ? t1 : 8'd0}), 64'({ev1, ev1 ? 8'(e1) : 8'd0}));
    endtask

    task automatic wr(int idx, int mode, logic [63:0] d, string req);
        int e0, e1;
        bit ev1;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_mode = 2'(mode); wr_data = d;
        #1;
        e0 = ptag(cur_cwp, idx);
        e1 = ptag(cur_cwp, idx + 1);
        ev1 = (mode == 2) && (e1 != 0);
        chk(req, "write tag0", 64'({wr_tag0_vld, wr_tag0_vld ? wr_tag0 : 8'd0}), 64'({e0 != 0, 8'(e0)}));
        chk(req, "write tag1", 64'({wr_tag1_vld, wr_tag1_vld ? wr_tag1 : 8'd0}), 64'({ev1, ev1 ? 8'(e1) : 8'd0}));
        @(posedge clk);
        model_upd(idx, mode, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ctl(int sel, int v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_sel = 3'(sel); ctl_wdata = 5'(v);
        @(posedge clk);
        @(negedge clk);
        ctl_we = 1'b0;
        if (sel == 0) cur_cwp = v;
    endtask

    task automatic ctr_chk(string req, int p, int s, int r, int o, int c);
        #1;
        chk(req, "win_ptr", 64'(win_ptr), 64'(p));
        chk(req, "save room", 64'(win_save_room), 64'(s));
        chk(req, "restore room", 64'(win_restore_room), 64'(r));
        chk(req, "other cnt", 64'(win_other_cnt), 64'(o));
        chk(req, "clean cnt", 64'(win_clean_cnt), 64'(c));
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] newv;
        rst_n = 1'b0; wr_en = 0; byp_en = 0; ctl_we = 0; ctl_sel = 0; ctl_wdata = 0;
        ra_idx = 0; rb_idx = 0; wr_idx = 0; ra_mode = 0; rb_mode = 0; wr_mode = 0; wr_data = 0;
        for (int t = 0; t < 136; t++) model[t] = 64'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ctr_chk("R10", 0, 6, 0, 0, 7);
        rd_chk(0, 0, 0, "R1");

        // Fill every physical entry through every window.
        for (int c = 0; c < 8; c++) begin
            ctl(0, c);
            for (int i = 1; i < 32; i++)
                wr(i, 0, {8'(c), 8'(i), 16'hBEEF, 32'hC000_0000 | 32'(c * 64 + i)}, (i < 8) ? "R2" : "R4");
        end
        wr(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R1");

        // Sweep all indices under every pointer value, all three modes.
        for (int c = 0; c < 8; c++) begin
            ctl(0, c);
            for (int i = 0; i < 32; i++) begin
                rd_chk(0, i, 0, (i == 0) ? "R1" : ((i < 8) ? "R2" : "R3"));
                rd_chk(1, i, 1, "R6");
                rd_chk(1, i, 2, (i == 31) ? "R8" : "R7");
            end
        end

        // R3 overlap: index 26 under pointer 3 is index 10 under pointer 2.
        ctl(0, 3);
        wr(26, 0, 64'h0BAD_F00D_1357_9BDF, "R3");
        ctl(0, 2);
        rd_chk(0, 10, 0, "R3");
        chk("R3", "overlap value", ra_data, 64'h0BAD_F00D_1357_9BDF);

        // R5: full-width value, also through the spare mode code.
        ctl(0, 5);
        wr(20, 0, 64'h8765_4321_0FED_CBA9, "R5");
        rd_chk(0, 20, 0, "R5");
        wr(21, 3, 64'hF0F0_0F0F_A5A5_5A5A, "R5");
        rd_chk(1, 21, 3, "R5");

        // R6: sign extension of 32-bit writes.
        wr(9, 1, 64'h1234_5678_8000_0001, "R6");
        rd_chk(0, 9, 0, "R6");
        chk("R6", "negative sext", ra_data, 64'hFFFF_FFFF_8000_0001);
        wr(9, 1, 64'hFFFF_0000_7FFF_FFFE, "R6");
        rd_chk(0, 9, 0, "R6");
        chk("R6", "positive sext", ra_data, 64'h0000_0000_7FFF_FFFE);

        // R7: paired writes within a group, global->window and across groups.
        wr(10, 2, 64'hDEAD_BEEF_CAFE_F00D, "R7");
        rd_chk(0, 10, 0, "R7");
        chk("R7", "pair high word", ra_data, 64'h0000_0000_DEAD_BEEF);
        rd_chk(0, 11, 0, "R7");
        chk("R7", "pair low word", ra_data, 64'h0000_0000_CAFE_F00D);
        rd_chk(1, 10, 2, "R7");
        wr(7, 2, 64'h1111_2222_3333_4444, "R7");
        rd_chk(0, 7, 0, "R7");
        rd_chk(0, 8, 0, "R7");
        wr(15, 2, 64'h5555_6666_7777_8888, "R7");
        rd_chk(1, 15, 2, "R7");

        // R8: paired access at the top index loses the second word.
        wr(31, 2, 64'h0123_4567_89AB_CDEF, "R8");
        rd_chk(0, 31, 0, "R8");
        rd_chk(1, 31, 2, "R8");
        chk("R8", "wrapped pair read", rb_data, 64'h0123_4567_0000_0000);
        rd_chk(0, 0, 0, "R8");

        // R9: same-cycle read with bypass off and on.
        ctl(0, 6);
        newv = 64'h7777_AAAA_5555_CCCC;
        @(negedge clk);
        wr_en = 1; wr_idx = 12; wr_mode = 0; wr_data = newv; byp_en = 0;
        ra_idx = 12; ra_mode = 0;
        #1;
        chk("R9", "no bypass old value", ra_data, mdat(ptag(6, 12)));
        byp_en = 1;
        #1;
        chk("R9", "bypass new value", ra_data, newv);
        @(posedge clk);
        model_upd(12, 0, newv);
        @(negedge clk);
        wr_en = 0; byp_en = 0;
        #1;
        chk("R9", "after edge", ra_data, newv);
        newv = 64'h2468_ACE0_1357_9BDF;
        @(negedge clk);
        wr_en = 1; wr_idx = 20; wr_mode = 2; wr_data = newv; byp_en = 1;
        ra_idx = 20; ra_mode = 2; rb_idx = 21; rb_mode = 0;
        #1;
        chk("R9", "pair bypass joined", ra_data, newv);
        chk("R9", "pair bypass low reg", rb_data, {32'd0, newv[31:0]});
        @(posedge clk);
        model_upd(20, 2, newv);
        @(negedge clk);
        wr_en = 0; byp_en = 0;

        // R10: counter loads, ignored selects, pointer taken modulo 8 (R3).
        ctl(1, 3); ctl(2, 2); ctl(3, 1); ctl(4, 4);
        ctr_chk("R10", 6, 3, 2, 1, 4);
        ctl(5, 31); ctl(7, 17);
        ctr_chk("R10", 6, 3, 2, 1, 4);
        ctl(0, 9);
        ctr_chk("R10", 9, 3, 2, 1, 4);
        rd_chk(0, 8, 0, "R3");
        rd_chk(1, 16, 0, "R3");

        // Final table sweep: nothing else was disturbed (R1, R8).
        for (int c = 0; c < 8; c++) begin
            ctl(0, c);
            for (int i = 0; i < 32; i++) rd_chk(0, i, 0, "R8");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule